// File: doc/BRIEF.md
# Fifteen-Cent Coin Credit Controller

This block is the control core of a coin-fed dispenser whose single item costs fifteen cents. Each clock cycle it may see a nickel pulse, a dime pulse, both or neither, and it keeps a running credit of 0, 5, 10 or 15 cents. When the credit reaches fifteen cents it raises a release output that drives the dispensing mechanism. It holds that output until a reset clears the credit.

No change is returned. Any amount paid beyond the price is lost, so the credit saturates at fifteen cents. Coin pulses are one cycle long and synchronous to the clock. Cleaning up the mechanical coin sensors is done upstream of this block. The release output is a Moore output: it depends only on the stored credit, so it moves only at a clock edge.

Top module: `vend15_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the credit becomes 0 cents and `open_o` is 0 after that edge.
- R2: A sampled-low `rst_n` wins over any coin pulse in the same cycle, so the credit still becomes 0 cents.
- R3: Below 15 cents, a cycle with neither `nickel_i` nor `dime_i` high leaves the credit unchanged.
- R4: A cycle with only `nickel_i` high adds 5 cents to the credit, saturating at 15 cents.
- R5: A cycle with only `dime_i` high adds 10 cents, saturating at 15 cents. A dime at 10 cents gives 15 cents, and no change is returned.
- R6: `open_o` is 1 exactly when the registered credit is 15 cents. It rises only in the cycle after the edge that stored the credit that completed the price.
- R7: Once the credit is 15 cents it stays there, with `open_o` high, until reset, whatever coins arrive.
- R8: When both pulses are high in the same cycle, the credit moves from 0 to 15 cents, from 5 to 10 cents, and from 10 or 15 cents to 15 cents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset that clears the credit |
| nickel_i | input | 1 | One-cycle pulse for an accepted 5-cent coin |
| dime_i | input | 1 | One-cycle pulse for an accepted 10-cent coin |
| open_o | output | 1 | Release command, high while the credit is 15 cents |

## Verification
The hardest cases to reach are the cycles where both coin pulses are high together. These cases are a don't-care slot of the minimized equations, and from 5 cents the result is 10 cents rather than a saturated 15 cents. Every sequence of up to four cycles drawn from idle, nickel, dime and both-together is applied from a fresh reset, so each such pair is met from every credit level. After that, a seeded random run mixes in resets that land on coin cycles.

// File: rtl/vend15_pkg.sv
`timescale 1ns/1ps
// Package vend15_pkg
// Shared credit type for the fifteen-cent controller. The bit values are
// fixed because the minimized next-state equations decode them directly.
package vend15_pkg;
    localparam int CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_t;
endpackage

// File: rtl/vend15_next.sv
`timescale 1ns/1ps
// Module vend15_next
// Combinational next-credit logic built from the hand-minimized sum-of-products
// forms. It assumes the credit encoding in vend15_pkg. It does not handle
// reset; the register stage applies reset.
module vend15_next
    import vend15_pkg::*;
(
    input  credit_t cur_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    output credit_t nxt_o
);
    logic hi_b;
    logic lo_b;
    logic nhi;
    logic nlo;

    // Split the current credit into its two state bits.
    always_comb begin
        hi_b = cur_i[1];
        lo_b = cur_i[0];
    end

    // Minimized equations for both next-state bits.
    always_comb begin
        nhi = hi_b | dime_i | (lo_b & nickel_i);
        nlo = (~lo_b & nickel_i) | (lo_b & ~nickel_i)
            | (hi_b & nickel_i) | (hi_b & dime_i);
        nxt_o = credit_t'({nhi, nlo});
    end
endmodule

// File: rtl/vend15_state_reg.sv
`timescale 1ns/1ps
// Module vend15_state_reg
// Credit register with synchronous active-low reset to the zero-credit
// state. Reset takes priority over the computed next value.
module vend15_state_reg
    import vend15_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_t nxt_i,
    output credit_t cur_o
);
    // Store the next credit each edge, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_o <= CR_0;
        else        cur_o <= nxt_i;
    end
endmodule

// File: rtl/vend15_open_dec.sv
`timescale 1ns/1ps
// Module vend15_open_dec
// Moore output decode. The release command is the AND of both credit bits,
// so it is true only in the full-price state.
module vend15_open_dec
    import vend15_pkg::*;
(
    input  credit_t cur_i,
    output logic    open_o
);
    // Decode the full-price state.
    always_comb open_o = cur_i[1] & cur_i[0];
endmodule

// File: rtl/vend15_ctrl.sv
`timescale 1ns/1ps
// Module vend15_ctrl
// Top level of the fifteen-cent coin controller. Coin pulses are assumed to
// be clean, one cycle long and synchronous to clk. Credit saturates at
// fifteen cents and holds there until reset.
module vend15_ctrl
    import vend15_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o
);
    credit_t state_q;
    credit_t state_d;

    vend15_next u_next (
        .cur_i    (state_q),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .nxt_o    (state_d)
    );

    vend15_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt_i (state_d),
        .cur_o (state_q)
    );

    vend15_open_dec u_open (
        .cur_i  (state_q),
        .open_o (open_o)
    );
endmodule

// File: rtl/vend15_ctrl_chk.sv
`timescale 1ns/1ps
// Module vend15_ctrl_chk
// Property checker attached to every vend15_ctrl instance through bind.
// It observes the ports and the registered credit.
module vend15_ctrl_chk
    import vend15_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    nickel_i,
    input logic    dime_i,
    input logic    open_o,
    input credit_t state_q
);
    // R1, R2: a sampled reset clears the credit and the release output.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (state_q == CR_0 && !open_o));

    // R3: an idle cycle below full price keeps the credit.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nickel_i && !dime_i && state_q != CR_15) |=> $stable(state_q));

    // R4: a lone nickel from zero gives five cents.
    p_nickel_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CR_0 && nickel_i && !dime_i) |=> (state_q == CR_5));

    // R5: a dime at ten cents reaches the price.
    p_dime_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CR_10 && dime_i) |=> open_o);

    // R6: the release output rises only after a coin cycle.
    p_open_moore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(nickel_i || dime_i));

    // R7: the release output holds until reset.
    p_open_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> open_o);

    // R8: both coins together at five cents give ten cents.
    p_both_from5_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CR_5 && nickel_i && dime_i) |=> (state_q == CR_10));
endmodule

bind vend15_ctrl vend15_ctrl_chk i_vend15_ctrl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .open_o   (open_o),
    .state_q  (state_q)
);

// File: tb/test_vend15_ctrl.sv
`timescale 1ns/1ps
// Bench for vend15_ctrl. It runs an exhaustive short-sequence sweep, then
// seeded random traffic, and compares against a credit model kept in cents.
module test_vend15_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic open_w;

    int n_checks = 0;
    int n_fail = 0;
    int model_c = 0;
    bit finished = 1'b0;

    vend15_ctrl i_vend15_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .nickel_i (nickel),
        .dime_i   (dime),
        .open_o   (open_w)
    );

    always #2.5 clk = ~clk;

    // Reference credit update taken from the requirements.
    function automatic int ref_next(int c, bit r_n, bit n, bit d);
        if (!r_n) return 0;
        if (n && d) return (c == 5) ? 10 : 15;
        if (d) return (c + 10 > 15) ? 15 : c + 10;
        if (n) return (c + 5 > 15) ? 15 : c + 5;
        return c;
    endfunction

    // Pick the requirement a step exercises.
    function automatic string tag_of(int c, bit r_n, bit n, bit d);
        if (!r_n) return (n || d) ? "R2" : "R1";
        if (c == 15) return "R7";
        if (n && d) return "R8";
        if (d) return "R5";
        if (n) return "R4";
        return "R3";
    endfunction

    task automatic check(string tag, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s open_o actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus and compare the output after the edge.
    task automatic step(bit r_n, bit n, bit d);
        string t;
        @(negedge clk);
        rst_n = r_n; nickel = n; dime = d;
        t = tag_of(model_c, r_n, n, d);
        @(posedge clk);
        #1;
        model_c = ref_next(model_c, r_n, n, d);
        check(t, open_w, model_c == 15);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(5 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog open_o actual=%0b expected=done", open_w);
        summary();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240517);
        // R1: reset state.
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);

        // R6: three nickels; open must stay low at 5 and 10, rise at 15.
        step(1'b1, 1'b1, 1'b0); check("R6", open_w, 1'b0);
        step(1'b1, 1'b0, 1'b0); check("R6", open_w, 1'b0);
        step(1'b1, 1'b1, 1'b0); check("R6", open_w, 1'b0);
        step(1'b1, 1'b1, 1'b0); check("R6", open_w, 1'b1);
        // R2: reset during a dime.
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1); check("R2", open_w, 1'b0);

        // Exhaustive: codes 0 idle, 1 nickel, 2 dime, 3 both.
        for (int len = 1; len <= 4; len++) begin
            for (int code = 0; code < (1 << (2 * len)); code++) begin
                step(1'b0, 1'b0, 1'b0);
                for (int k = 0; k < len; k++) begin
                    int sym;
                    sym = (code >> (2 * k)) & 3;
                    step(1'b1, sym[0], sym[1]);
                end
            end
        end

        // Seeded random mix with occasional resets.
        for (int i = 0; i < 3000; i++) begin
            bit r_n;
            r_n = ($urandom % 12) != 0;
            step(r_n, $urandom % 3 == 0, $urandom % 4 == 0);
        end

        @(negedge clk);
        nickel = 1'b0; dime = 1'b0;
        summary();
    end
endmodule